// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block sits between a host register bus and the byte-wide peripheral side of a parallel port. It serves the enhanced-mode address cycle (offset 3) and data cycle (offset 4). A host access at either offset goes to a one-byte request/acknowledge handshake only when the stored control bits select the matching mode. Writes need a pattern that differs from the one reads need. A cycle that is gated off finishes at once and has no effect on the peripheral side.

A data access at offset 4 can be one, two or four bytes wide. Wide accesses are broken into single bytes, least-significant byte first. The bytes run back to back and the sequence stops at the first byte the peripheral rejects. Any peripheral error sets a sticky timeout flag. The flag appears as bit 0 of the status register (offset 1), and writing a 1 to that bit clears it. The extended-capability window at base + 0x400 is decoded as inert, and so are all other offsets. The host holds `req_i` and waits until `done_o` pulses.

Top module: `epp_cycle_gate`

## Requirements
- R1: An access at offset 3 (address cycle, `per_addr_o`=1) or offset 4 (data cycle, `per_addr_o`=0) is sent to the peripheral when its mode check passes. The offset is `addr_i[2:0]`, and `addr_i[10:3]` must be zero.
- R2: A write is sent only when `ctrl_i & 8'h2F` equals `8'h04`. Control bits 7, 6 and 4 do not matter. Otherwise the write completes one cycle after acceptance and makes no peripheral request.
- R3: A read is sent only when `ctrl_i & 8'h2F` equals `8'h24`. Otherwise the read completes one cycle after acceptance with `rdata_o` = 32'hFFFFFFFF and makes no peripheral request.
- R4: At offset 4, `size_i` sets the byte count: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Byte i is `wdata_i[8i+7:8i]` or read lane i, and bytes go out in ascending i. Offset 3 always moves one byte. Read lanes that receive no byte read 8'hFF.
- R5: Each byte holds `per_req_o` with stable `per_we_o`, `per_addr_o` and `per_wdata_o` until `per_ack_i`. The next byte is requested in the cycle after an acknowledge. `done_o` pulses for one cycle, one cycle after the final acknowledge, so an N-byte access with a d-cycle acknowledge latency takes 1 + N(d+1) cycles from acceptance to `done_o`.
- R6: An acknowledge with `per_err_i` ends the access after that byte and sets the sticky timeout flag. The failing byte's lane and all later lanes read 8'hFF. Later successful cycles leave the flag set.
- R7: A read at offset 1 returns {24'hFFFFFF, `status_i[7:1]`, flag}. A write at offset 1 with `wdata_i[0]`=1 clears the flag, and one with `wdata_i[0]`=0 has no effect. Both complete in one cycle.
- R8: An access in the window 0x400 to 0x407 completes in one cycle. Writes there are ignored and reads return 32'hFFFFFFFF, with no peripheral request.
- R9: Reset clears the timeout flag and leaves `per_req_o` and `done_o` low.
- R10: Accesses at offsets 0, 2, 5, 6 and 7 complete in one cycle. They make no peripheral request, and reads there return 32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, held until done_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (11) | Register address relative to port base |
| size_i | input | 2 | Access width code for offset 4 |
| wdata_i | input | 32 | Host write data |
| ctrl_i | input | 8 | Stored control register bits |
| status_i | input | 7 | Status pin levels, bits 7..1 |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid while done_o |
| per_req_o | output | 1 | Peripheral byte request |
| per_we_o | output | 1 | Peripheral byte direction, 1 = write |
| per_addr_o | output | 1 | 1 = address cycle, 0 = data cycle |
| per_wdata_o | output | 8 | Byte sent to the peripheral |
| per_ack_i | input | 1 | Peripheral byte acknowledge |
| per_err_i | input | 1 | Error qualifier on acknowledge |
| per_rdata_i | input | 8 | Byte from the peripheral |

## Verification
The bench checks the mode patterns against near misses, for example a write under the read pattern and a pattern with only one stray low bit. A gate that tested too few bits would send bytes the peripheral should never see. Wide transfers are checked for byte order, acknowledge latency and an error in the middle. Wrong lane placement or a missing stop at the first error would show up as a swapped or extra byte in the peripheral log, or as a wrong cycle count. The sticky flag is checked by reading it back through status after a clear with bit 0 at zero, after a later successful cycle, and across a reset. A flag that was not sticky, or that cleared on the wrong value, would show a wrong bit 0.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;
  localparam int IDX_W = $clog2(LANES);

  localparam logic [7:0] CTRL_MASK = 8'h2F;
  localparam logic [7:0] MODE_WR   = 8'h04;
  localparam logic [7:0] MODE_RD   = 8'h24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic             fwd;
    logic             addr_cyc;
    logic [IDX_W-1:0] last_idx;
    logic             clr_flag;
  } dec_t;
endpackage

// File: rtl/epp_gate_decode.sv
module epp_gate_decode
  import epp_gate_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic              wbit0_i,
  input  logic [7:0]        ctrl_i,
  input  logic [7:1]        status_i,
  input  logic              flag_i,
  output dec_t              dec_o,
  output logic [BUS_W-1:0]  local_rdata_o
);
  logic [2:0] off;
  logic       in_std;
  logic       mode_ok;

  assign off     = addr_i[2:0];
  assign in_std  = (addr_i[ADDR_W-1:3] == '0);
  assign mode_ok = ((ctrl_i & CTRL_MASK) == (we_i ? MODE_WR : MODE_RD));

  always_comb begin
    dec_o         = '0;
    local_rdata_o = '1;
    if (in_std) begin
      unique case (off)
        3'd1: begin
          local_rdata_o  = {{(BUS_W-8){1'b1}}, status_i, flag_i};
          dec_o.clr_flag = we_i & wbit0_i;
        end
        3'd3: begin
          dec_o.fwd      = mode_ok;
          dec_o.addr_cyc = 1'b1;
        end
        3'd4: begin
          dec_o.fwd = mode_ok;
          unique case (size_i)
            2'd0:    dec_o.last_idx = IDX_W'(0);
            2'd1:    dec_o.last_idx = IDX_W'(1);
            default: dec_o.last_idx = IDX_W'(LANES - 1);
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/epp_gate_flag.sv
module epp_gate_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R6: flag only rises after a peripheral error
  a_r6_set_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(set_i));
  // R7: flag only falls after a clearing status write
  a_r7_clear_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(clr_i));
endmodule

// File: rtl/epp_gate_engine.sv
module epp_gate_engine
  import epp_gate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             we_i,
  input  logic             fwd_i,
  input  logic             addr_cyc_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [BUS_W-1:0] local_rdata_i,
  output logic             accept_o,
  output logic             err_o,
  output logic             done_o,
  output logic [BUS_W-1:0] rdata_o,
  output logic             per_req_o,
  output logic             per_we_o,
  output logic             per_addr_o,
  output logic [7:0]       per_wdata_o,
  input  logic             per_ack_i,
  input  logic             per_err_i,
  input  logic [7:0]       per_rdata_i
);
  eng_state_e       state_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [BUS_W-1:0] wbuf_q, rdata_q;
  logic             we_q, addr_q;

  assign accept_o    = start_i && (state_q == ST_IDLE);
  assign per_req_o   = (state_q == ST_XFER);
  assign per_we_o    = we_q;
  assign per_addr_o  = addr_q;
  assign per_wdata_o = wbuf_q[{idx_q, 3'b000} +: 8];
  assign err_o       = per_req_o && per_ack_i && per_err_i;
  assign done_o      = (state_q == ST_DONE);
  assign rdata_o     = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      wbuf_q  <= '0;
      rdata_q <= '1;
      we_q    <= 1'b0;
      addr_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (fwd_i) begin
            we_q    <= we_i;
            addr_q  <= addr_cyc_i;
            wbuf_q  <= wdata_i;
            last_q  <= last_i;
            idx_q   <= '0;
            rdata_q <= '1;
            state_q <= ST_XFER;
          end else begin
            rdata_q <= local_rdata_i;
            state_q <= ST_DONE;
          end
        end
        ST_XFER: if (per_ack_i) begin
          if (per_err_i) begin
            state_q <= ST_DONE;
          end else begin
            if (!we_q) rdata_q[{idx_q, 3'b000} +: 8] <= per_rdata_i;
            if (idx_q == last_q) state_q <= ST_DONE;
            else                 idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: request and byte held until acknowledged
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_req_o && !per_ack_i |=> per_req_o && $stable(per_wdata_o)
                               && $stable(per_we_o) && $stable(per_addr_o));
  // R6: an error ends the access at once
  a_r6_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_req_o && per_ack_i && per_err_i |=> done_o && !per_req_o);
  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_gate_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [7:0]        ctrl_i,
  input  logic [7:1]        status_i,
  output logic              done_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              per_req_o,
  output logic              per_we_o,
  output logic              per_addr_o,
  output logic [7:0]        per_wdata_o,
  input  logic              per_ack_i,
  input  logic              per_err_i,
  input  logic [7:0]        per_rdata_i
);
  dec_t             dec;
  logic [BUS_W-1:0] local_rdata;
  logic             flag, accept, err;

  epp_gate_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i        (addr_i),
    .we_i          (we_i),
    .size_i        (size_i),
    .wbit0_i       (wdata_i[0]),
    .ctrl_i        (ctrl_i),
    .status_i      (status_i),
    .flag_i        (flag),
    .dec_o         (dec),
    .local_rdata_o (local_rdata)
  );

  epp_gate_engine u_eng (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (req_i),
    .we_i          (we_i),
    .fwd_i         (dec.fwd),
    .addr_cyc_i    (dec.addr_cyc),
    .last_i        (dec.last_idx),
    .wdata_i       (wdata_i),
    .local_rdata_i (local_rdata),
    .accept_o      (accept),
    .err_o         (err),
    .done_o        (done_o),
    .rdata_o       (rdata_o),
    .per_req_o     (per_req_o),
    .per_we_o      (per_we_o),
    .per_addr_o    (per_addr_o),
    .per_wdata_o   (per_wdata_o),
    .per_ack_i     (per_ack_i),
    .per_err_i     (per_err_i),
    .per_rdata_i   (per_rdata_i)
  );

  epp_gate_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err),
    .clr_i  (accept && dec.clr_flag),
    .flag_o (flag)
  );

  // R1: peripheral traffic only starts from a host request
  a_r1_fwd_from_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(per_req_o) |-> $past(req_i));
endmodule

// File: tb/tb_epp_cycle_gate.sv
module tb_epp_cycle_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [10:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  ctrl = 8'h0C;
  logic [7:1]  status = 7'b0101101;  // bits 7..1 of 8'h5A
  logic        done;
  logic [31:0] rdata;
  logic        per_req, per_we, per_addr;
  logic [7:0]  per_wdata;
  logic        per_ack = 1'b0, per_err = 1'b0;
  logic [7:0]  per_rdata = '0;

  always #10 clk = ~clk;

  epp_cycle_gate dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .ctrl_i(ctrl), .status_i(status),
    .done_o(done), .rdata_o(rdata), .per_req_o(per_req), .per_we_o(per_we),
    .per_addr_o(per_addr), .per_wdata_o(per_wdata), .per_ack_i(per_ack),
    .per_err_i(per_err), .per_rdata_i(per_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  int per_delay = 0, per_err_at = -1, per_seen = 0, wait_cnt = 0;
  bit exp_fwd = 0, in_task = 0, to_exp = 0, reported = 0;
  logic [9:0] plog[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // peripheral model plus per-clock idle checks
  initial forever begin
    @(negedge clk);
    per_ack = 1'b0;
    per_err = 1'b0;
    if (rst_n) begin
      chk("R1 no request outside forwarded access", {31'd0, per_req}, {31'd0, per_req & exp_fwd});
      chk("R5 no done outside access", {31'd0, done}, {31'd0, done & in_task});
    end
    if (rst_n && per_req) begin
      if (wait_cnt >= per_delay) begin
        per_ack   = 1'b1;
        per_err   = (per_seen == per_err_at);
        per_rdata = 8'hA0 + 8'(per_seen);
        plog.push_back({per_we, per_addr, per_we ? per_wdata : 8'h00});
        per_seen++;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  task automatic access(input string tag, input bit w, input logic [10:0] a,
                        input logic [1:0] sz, input logic [31:0] wd, input bit fwd,
                        input int sent, input logic [31:0] rexp, input int cexp);
    int cyc;
    logic [31:0] rd;
    @(negedge clk);
    per_seen = 0;
    wait_cnt = 0;
    plog.delete();
    in_task = 1;
    exp_fwd = fwd;
    we = w; addr = a; size = sz; wdata = wd; req = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!done && cyc < 300);
    rd = rdata;
    req = 1'b0;
    if (!w) chk({tag, " rdata"}, rd, rexp);
    chk({tag, " cycles"}, cyc, cexp);
    chk({tag, " bytes"}, plog.size(), sent);
    for (int i = 0; i < sent && i < plog.size(); i++)
      chk({tag, " byte"}, {22'd0, plog[i]},
          {22'd0, w, (a[2:0] == 3'd3), w ? wd[8*i +: 8] : 8'h00});
    @(negedge clk);
    in_task = 0;
    exp_fwd = 0;
    per_err_at = -1;
    per_delay = 0;
  endtask

  task automatic status_chk(input string tag);
    access(tag, 0, 11'h001, 2'd0, 0, 0, 0, {24'hFFFFFF, 8'h5A | {7'd0, to_exp}}, 1);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 per_req after reset", {31'd0, per_req}, 32'd0);
    chk("R9 done after reset", {31'd0, done}, 32'd0);
    status_chk("R9 R7 status after reset");

    // R1 R2 address write in write mode
    ctrl = 8'h04;
    access("R1 R2 addr write", 1, 11'h003, 2'd0, 32'h0000_00C3, 1, 1, 0, 2);
    ctrl = 8'hD4;
    access("R2 data write upper ctrl bits", 1, 11'h004, 2'd0, 32'h0000_005E, 1, 1, 0, 2);
    ctrl = 8'h24;
    access("R2 write under read mode", 1, 11'h004, 2'd0, 32'h0000_0077, 0, 0, 0, 1);
    ctrl = 8'h05;
    access("R2 write stray strobe bit", 1, 11'h003, 2'd0, 32'h0000_0077, 0, 0, 0, 1);

    // R3 reads
    ctrl = 8'h24;
    access("R3 R1 addr read", 0, 11'h003, 2'd0, 0, 1, 1, 32'hFFFF_FFA0, 2);
    ctrl = 8'h04;
    access("R3 read under write mode", 0, 11'h004, 2'd2, 0, 0, 0, 32'hFFFF_FFFF, 1);
    ctrl = 8'h2C;
    access("R3 read stray select bit", 0, 11'h003, 2'd0, 0, 0, 0, 32'hFFFF_FFFF, 1);

    // R4 R5 wide transfers
    ctrl = 8'h04;
    access("R4 word write", 1, 11'h004, 2'd2, 32'h1122_3344, 1, 4, 0, 5);
    per_delay = 2;
    access("R5 word write delayed", 1, 11'h004, 2'd3, 32'hCAFE_F00D, 1, 4, 0, 13);
    access("R4 addr cycle ignores size", 1, 11'h003, 2'd2, 32'h8899_AABB, 1, 1, 0, 2);
    ctrl = 8'h24;
    access("R4 half read", 0, 11'h004, 2'd1, 0, 1, 2, 32'hFFFF_A1A0, 3);
    per_delay = 1;
    access("R4 R5 word read delayed", 0, 11'h004, 2'd2, 0, 1, 4, 32'hA3A2_A1A0, 9);

    // R6 error handling
    per_err_at = 2;
    access("R6 word read error at byte 2", 0, 11'h004, 2'd2, 0, 1, 3, 32'hFFFF_A1A0, 4);
    to_exp = 1;
    status_chk("R6 R7 flag visible");
    ctrl = 8'h04;
    per_err_at = 0; per_delay = 1;
    access("R6 word write error at byte 0", 1, 11'h004, 2'd2, 32'h5566_7788, 1, 1, 0, 3);
    access("R6 success after error", 1, 11'h003, 2'd0, 32'h0000_0011, 1, 1, 0, 2);
    status_chk("R6 flag sticky");

    // R7 status writes
    access("R7 status write bit0 zero", 1, 11'h001, 2'd0, 32'hFFFF_FFFE, 0, 0, 0, 1);
    status_chk("R7 no clear on zero");
    access("R7 status write bit0 one", 1, 11'h001, 2'd0, 32'h0000_0001, 0, 0, 0, 1);
    to_exp = 0;
    status_chk("R7 cleared");

    // R8 extended window
    access("R8 window write", 1, 11'h404, 2'd2, 32'h1234_5678, 0, 0, 0, 1);
    access("R8 window write offset3", 1, 11'h403, 2'd0, 32'h0000_0012, 0, 0, 0, 1);
    access("R8 window read", 0, 11'h407, 2'd0, 0, 0, 0, 32'hFFFF_FFFF, 1);

    // R10 other offsets
    access("R10 offset0 read", 0, 11'h000, 2'd0, 0, 0, 0, 32'hFFFF_FFFF, 1);
    access("R10 offset2 read", 0, 11'h002, 2'd0, 0, 0, 0, 32'hFFFF_FFFF, 1);
    access("R10 offset0 write", 1, 11'h000, 2'd0, 32'h0000_00AB, 0, 0, 0, 1);
    access("R10 offset7 write", 1, 11'h007, 2'd0, 32'h0000_00AB, 0, 0, 0, 1);

    // R9 reset clears flag
    per_err_at = 0;
    access("R9 set flag", 1, 11'h003, 2'd0, 32'h0000_0001, 1, 1, 0, 2);
    to_exp = 1;
    status_chk("R9 flag before reset");
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    to_exp = 0;
    status_chk("R9 flag cleared by reset");

    report();
  end
endmodule